// File: doc/BRIEF.md
# Button-Ramped Controller Value Generator

This block watches an 8-bit button status byte that is sampled on each poll tick. It keeps two 7-bit controller values, X and Y. While a direction button is held together with the modifier button for its axis, that axis value is stepped slowly up or down. Four per-direction accumulators set the stepping rate. A start or select press returns both values to the centre.

Whenever a value differs from the copy last sent, the block builds a three-byte MIDI control-change message. It writes that message into a circular byte queue. The queue drains through a valid/ready byte stream toward a serial transmitter, one byte each time the transmitter reports it can take one. The channel, the controller numbers and the queue depth are parameters.

Top module: `cc_ramp_gen`

## Requirements
- R1: On reset, X and Y are 0x40, all four accumulators are zero, the overflow flag is clear and the queue is empty. The stream then delivers a Y message followed by an X message, both carrying 0x40.
- R2: On a tick with bit 3 (start) or bit 2 (select) set, both values become 0x40. No stepping takes place on that tick and the accumulators are left as they are.
- R3: Y steps only on ticks with bit 1 held. Up (bit 4) and down (bit 5) each add 3 to their own 8-bit accumulator. Up is evaluated before down within a tick.
- R4: X steps only on ticks with bit 0 held. Left (bit 6) and right (bit 7) each add 2 to their own 8-bit accumulator. Left is evaluated before right within a tick.
- R5: An accumulator fires when its bit 3 is set after the add. A fire moves the value by one: up and right increment, down and left decrement. It then zeroes both accumulators of that axis.
- R6: Values stay in 0..127. A fire at the limit leaves the value and both accumulators unchanged.
- R7: A message is produced only when a value differs from its last sent copy. It consists of 0xB0 OR channel (default 0x0E, giving 0xBE), then the controller number (7 for Y, 10 for X), then the value.
- R8: When both values change, the Y message is queued completely before the X message, and no bytes of the two messages interleave.
- R9: X and Y change only on cycles where tick is high.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value. A byte leaves only on a cycle with both signals high.
- R11: The queue holds 2^PTR_W-1 bytes. A byte written while the queue is full is dropped and sets overflow, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle poll strobe |
| buttons | input | 8 | Button status, 1 = pressed |
| x_value | output | 7 | Current X controller value |
| y_value | output | 7 | Current Y controller value |
| out_data | output | 8 | Head byte of the transmit queue |
| out_valid | output | 1 | Queue holds a byte |
| out_ready | input | 1 | Transmitter can accept a byte |
| overflow | output | 1 | Sticky: a byte was dropped on a full queue |

## Verification
The assertions place no limit on out_ready or on the button byte. The one-step-per-tick property assumes only that tick is a strobe, and the bench holds it high for a single cycle. The byte-exact stream comparison also relies on ticks arriving at least seven cycles apart, so that each tick produces at most one Y and one X message before the next tick. The bench spaces ticks twelve cycles apart and keeps that spacing under random backpressure and with the queue stalled into overflow.

// File: rtl/cc_ramp_gen.sv
module cc_ramp_gen #(
  parameter logic [3:0] CHANNEL = 4'hE,
  parameter int         PTR_W   = 8,
  parameter logic [6:0] CENTER  = 7'h40,
  parameter logic [7:0] STEP_Y  = 8'd3,
  parameter logic [7:0] STEP_X  = 8'd2,
  parameter logic [7:0] CTL_X   = 8'd10,
  parameter logic [7:0] CTL_Y   = 8'd7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] buttons,
  output logic [6:0] x_value,
  output logic [6:0] y_value,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       overflow
);
  localparam int DEPTH = 1 << PTR_W;
  localparam logic [6:0] VMAX = 7'h7F;
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [7:0] acc_up, acc_dn, acc_lf, acc_rt;
  logic [7:0] n_up, n_dn, n_lf, n_rt;
  logic [6:0] nx, ny;
  wire recenter = buttons[3] | buttons[2];

  always_comb begin
    nx = x_value; ny = y_value;
    n_up = acc_up; n_dn = acc_dn; n_lf = acc_lf; n_rt = acc_rt;
    if (recenter) begin
      nx = CENTER;
      ny = CENTER;
    end else begin
      if (buttons[1]) begin
        if (buttons[4]) begin
          n_up = n_up + STEP_Y;
          if (n_up[3] && ny != VMAX) begin ny = ny + 7'd1; n_up = '0; n_dn = '0; end
        end
        if (buttons[5]) begin
          n_dn = n_dn + STEP_Y;
          if (n_dn[3] && ny != 7'd0) begin ny = ny - 7'd1; n_up = '0; n_dn = '0; end
        end
      end
      if (buttons[0]) begin
        if (buttons[6]) begin
          n_lf = n_lf + STEP_X;
          if (n_lf[3] && nx != 7'd0) begin nx = nx - 7'd1; n_lf = '0; n_rt = '0; end
        end
        if (buttons[7]) begin
          n_rt = n_rt + STEP_X;
          if (n_rt[3] && nx != VMAX) begin nx = nx + 7'd1; n_lf = '0; n_rt = '0; end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      x_value <= CENTER; y_value <= CENTER;
      acc_up <= '0; acc_dn <= '0; acc_lf <= '0; acc_rt <= '0;
    end else if (tick) begin
      x_value <= nx; y_value <= ny;
      acc_up <= n_up; acc_dn <= n_dn; acc_lf <= n_lf; acc_rt <= n_rt;
    end

  logic [7:0] last_x, last_y, push_byte;
  logic [1:0] phase;
  logic       send_x;
  logic [6:0] snap;
  wire y_dirty = {1'b0, y_value} != last_y;
  wire x_dirty = {1'b0, x_value} != last_x;
  wire start   = (phase == 2'd0) && (y_dirty || x_dirty);
  wire push    = start || (phase != 2'd0);

  always_comb
    case (phase)
      2'd1:    push_byte = send_x ? CTL_X : CTL_Y;
      2'd2:    push_byte = {1'b0, snap};
      default: push_byte = {4'hB, CHANNEL};
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= 2'd0; send_x <= 1'b0; snap <= '0;
      last_x <= 8'hFF; last_y <= 8'hFF;
    end else begin
      case (phase)
        2'd0: if (start) begin
          phase  <= 2'd1;
          send_x <= !y_dirty;
          if (y_dirty) begin snap <= y_value; last_y <= {1'b0, y_value}; end
          else         begin snap <= x_value; last_x <= {1'b0, x_value}; end
        end
        2'd1:    phase <= 2'd2;
        default: phase <= 2'd0;
      endcase
    end

  logic [7:0] mem [DEPTH];
  logic [PTR_W-1:0] head, tail;
  wire full = (head + ONE) == tail;
  wire pop  = out_valid && out_ready;
  assign out_valid = head != tail;
  assign out_data  = mem[tail];

  always_ff @(posedge clk)
    if (push && !full) mem[head] <= push_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      head <= '0; tail <= '0; overflow <= 1'b0;
    end else begin
      if (push && !full) head <= head + ONE;
      if (push && full)  overflow <= 1'b1;
      if (pop)           tail <= tail + ONE;
    end

  assert_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(x_value) && $stable(y_value)));
  assert_center_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && recenter) |=> (x_value == CENTER && y_value == CENTER));
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !recenter) |=> (x_value == $past(x_value) || x_value == $past(x_value) + 7'd1 ||
                             x_value == $past(x_value) - 7'd1) &&
                            (y_value == $past(y_value) || y_value == $past(y_value) + 7'd1 ||
                             y_value == $past(y_value) - 7'd1));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_sticky_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: tb/sim_cc_ramp_gen.sv
module sim_cc_ramp_gen;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, tick = 0, out_ready = 0;
  logic [7:0] buttons = 0;
  wire [6:0] x_value, y_value;
  wire [7:0] out_data;
  wire out_valid, overflow;

  always #(PERIOD/2) clk = ~clk;

  cc_ramp_gen u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .buttons(buttons),
    .x_value(x_value), .y_value(y_value), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .overflow(overflow));

  int total = 0, bad = 0, exp_n = 0, rx_n = 0, rdy_mode = 1;
  logic [7:0] exp_buf [16384];
  logic [7:0] rx_buf [16384];
  logic [6:0] mx, my;
  logic [7:0] ma [4];
  logic [7:0] lx, ly;
  logic [15:0] lfsr = 16'hACE1;
  logic held = 0;
  logic [7:0] held_data = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= (rdy_mode == 2) ? (lfsr[1:0] != 2'b00) : (rdy_mode == 1);
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (held) check(out_valid && out_data == held_data, "R10 hold", int'(out_data), int'(held_data));
      if (out_valid && out_ready) begin rx_buf[rx_n] = out_data; rx_n++; end
      held = out_valid && !out_ready;
      held_data = out_data;
    end else held = 0;
  end

  task automatic push3(input logic [7:0] ctl, input logic [6:0] v);
    exp_buf[exp_n] = 8'hBE; exp_buf[exp_n+1] = ctl; exp_buf[exp_n+2] = {1'b0, v};
    exp_n += 3;
  endtask

  task automatic emit();
    if ({1'b0, my} != ly) begin push3(8'd7, my); ly = {1'b0, my}; end
    if ({1'b0, mx} != lx) begin push3(8'd10, mx); lx = {1'b0, mx}; end
  endtask

  task automatic model_tick(input logic [7:0] b);
    if (b[3] | b[2]) begin mx = 7'h40; my = 7'h40; end
    else begin
      if (b[1]) begin
        if (b[4]) begin ma[0] += 8'd3; if (ma[0][3] && my != 7'd127) begin my++; ma[0] = 0; ma[1] = 0; end end
        if (b[5]) begin ma[1] += 8'd3; if (ma[1][3] && my != 7'd0) begin my--; ma[0] = 0; ma[1] = 0; end end
      end
      if (b[0]) begin
        if (b[6]) begin ma[2] += 8'd2; if (ma[2][3] && mx != 7'd0) begin mx--; ma[2] = 0; ma[3] = 0; end end
        if (b[7]) begin ma[3] += 8'd2; if (ma[3][3] && mx != 7'd127) begin mx++; ma[2] = 0; ma[3] = 0; end end
      end
    end
    emit();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tick = 0; buttons = 0;
    repeat (3) @(negedge clk);
    check(x_value == 7'h40 && y_value == 7'h40, "R1 reset values", int'(x_value), 64);
    check(!out_valid && !overflow, "R1 reset queue", int'({out_valid, overflow}), 0);
    rx_n = 0; exp_n = 0;
    mx = 7'h40; my = 7'h40; lx = 8'hFF; ly = 8'hFF;
    for (int i = 0; i < 4; i++) ma[i] = 0;
    emit();
    rst_n = 1;
  endtask

  task automatic do_tick(input logic [7:0] b, input string tag);
    @(negedge clk);
    buttons = b; tick = 1;
    model_tick(b);
    @(negedge clk);
    tick = 0;
    repeat (10) @(negedge clk);
    check(x_value == mx, {tag, " x"}, int'(x_value), int'(mx));
    check(y_value == my, {tag, " y"}, int'(y_value), int'(my));
  endtask

  task automatic drain_compare(input string tag);
    rdy_mode = 1;
    repeat (600) @(negedge clk);
    check(rx_n == exp_n, {tag, " byte count"}, rx_n, exp_n);
    for (int i = 0; i < exp_n && i < rx_n; i++)
      check(rx_buf[i] == exp_buf[i], {tag, " byte"}, int'(rx_buf[i]), int'(exp_buf[i]));
    check(!out_valid, {tag, " drained"}, int'(out_valid), 0);
  endtask

  initial begin
    rdy_mode = 1;
    do_reset();
    drain_compare("R1 centering messages");
    rdy_mode = 2;
    for (int p = 0; p < 256; p++)
      for (int t = 0; t < 3; t++)
        do_tick(8'(p), "R2 R3 R4 R5 sweep");
    drain_compare("R7 R8 R10 sweep stream");
    rdy_mode = 1;
    for (int i = 0; i < 450; i++) do_tick(8'h12, "R6 up clamp");
    check(y_value == 7'd127, "R6 y top", int'(y_value), 127);
    for (int i = 0; i < 450; i++) do_tick(8'h22, "R6 down clamp");
    check(y_value == 7'd0, "R6 y bottom", int'(y_value), 0);
    for (int i = 0; i < 560; i++) do_tick(8'h81, "R6 right clamp");
    check(x_value == 7'd127, "R6 x top", int'(x_value), 127);
    for (int i = 0; i < 560; i++) do_tick(8'h41, "R6 left clamp");
    check(x_value == 7'd0, "R6 x bottom", int'(x_value), 0);
    do_tick(8'h08, "R2 start");
    do_tick(8'h04, "R2 select");
    do_tick(8'h12, "R5 clear"); do_tick(8'h12, "R5 clear");
    do_tick(8'h22, "R5 clear"); do_tick(8'h12, "R5 clear");
    do_tick(8'h22, "R5 clear"); do_tick(8'h22, "R5 clear");
    do_tick(8'h10, "R3 gate"); do_tick(8'h80, "R4 gate");
    do_tick(8'h33, "R3 order"); do_tick(8'hC1, "R4 order");
    drain_compare("R7 R8 directed stream");

    rdy_mode = 0;
    do_reset();
    for (int i = 0; i < 200; i++) do_tick(8'h93, "R11 fill");
    check(overflow, "R11 overflow set", int'(overflow), 1);
    check(exp_n > 255, "R11 excess bytes", exp_n, 256);
    if (exp_n > 255) exp_n = 255;
    drain_compare("R11 kept bytes");
    check(overflow, "R11 overflow sticky", int'(overflow), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule